// File: doc/BRIEF.md
# Peak-Current PWM Switch Latch

This block decides, one system clock at a time, whether the power switch of a current-mode buck converter is on. A free-running cycle clock starts every switching period. That clock is synchronized and reduced to a single set event per rising edge, and the set event turns the gate output on. A comparator compares the sensed inductor current against an externally supplied peak threshold. Its output is active low, and it is synchronized before use. When it goes low, the on-time ends.

Two programmable counts shape each pulse. A blanking window hides the comparator for a number of clocks after turn-on, so the switching spike cannot end the pulse early. A maximum on-time ends the pulse when the comparator never trips. When set and trip arrive together, the trip wins. Each detected cycle edge also produces a one-clock start strobe for neighbouring logic. The enable input forces the gate off and ignores new cycle edges.

Top module: `pcm_pwm_latch`

## Requirements
- R1: While rst_ni is low, gate_o and cyc_start_o are 0.
- R2: A rising edge on cyc_clk_i, with en_i high and cmp_ni high, drives gate_o high on the third rising clock edge after the input changes. That is two synchronizer flops plus the latch.
- R3: A cycle clock held high produces only one set. After the pulse ends, gate_o stays low until cyc_clk_i has gone low and high again.
- R4: cyc_start_o is high for exactly one clock, in the same cycle in which gate_o would rise, for every detected cycle edge while en_i is high. This includes edges that R8 suppresses.
- R5: cmp_ni low (active low trip, after a two-flop synchronizer) ends the pulse once blanking is over. With blank_cnt_i = 0, a trip applied in the first on-cycle gives a 3-clock pulse.
- R6: Leading-edge blanking ignores the trip while the on-count is below blank_cnt_i. The shortest pulse that a trip can end is blank_cnt_i + 1 clocks.
- R7: A pulse that is not tripped lasts exactly max_on_i clocks. A value of 0 acts as 1.
- R8: If a set event and a synchronized trip occur in the same clock, gate_o stays low, or goes low if it was high.
- R9: With en_i low, gate_o is 0 after the next clock edge, cycle edges are ignored, and no start strobe is emitted.
- R10: A new set event while gate_o is high restarts the blanking and on-time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables switching; low forces the gate off |
| cyc_clk_i | input | 1 | Free-running switching-cycle clock, asynchronous |
| cmp_ni | input | 1 | Peak-current comparator, low means the limit is reached |
| blank_cnt_i | input | CNT_W | Blanking length in clocks after turn-on |
| max_on_i | input | CNT_W | Maximum on-time in clocks |
| gate_o | output | 1 | Power switch gate drive |
| cyc_start_o | output | 1 | One-clock strobe per detected cycle edge |

## Verification
The bench first goes after the width of single pulses:
- A design that counts blanking or the maximum on-time off by one produces pulses one clock too long or too short.
- A design that treats the cycle clock as a level fires again while the cycle clock stays high.

It also drives a trip exactly on the set edge. A design that lets the set win turns the switch on into an active current limit.

It retriggers mid-pulse and toggles enable in random traffic. A design that is wrong here either fails to restart its count or keeps the gate on while disabled.

// File: rtl/pcm_pwm_pkg.sv
package pcm_pwm_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= RST_VAL;
      else if (g == 0) pipe_q[g] <= d_i;
      else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pcm_edge_det.sv
module pcm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

  assert_rise_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pcm_on_timer.sv
module pcm_on_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] blank_i,
  input  logic [CNT_W-1:0] max_i,
  output logic             blank_done_o,
  output logic             max_hit_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign blank_done_o = (cnt_q >= blank_i);
  // widen by one bit so the +1 cannot wrap
  assign max_hit_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, max_i};
endmodule

// File: rtl/pcm_pwm_latch.sv
module pcm_pwm_latch
  import pcm_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cyc_clk_i,
  input  logic             cmp_ni,
  input  logic [CNT_W-1:0] blank_cnt_i,
  input  logic [CNT_W-1:0] max_on_i,
  output logic             gate_o,
  output logic             cyc_start_o
);
  logic cyc_sync, cmp_sync, cyc_rise;
  logic set_pulse, trip, blank_done, max_hit;
  logic gate_q, start_q;

  pcm_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) u_cyc_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cyc_clk_i), .q_o(cyc_sync));

  pcm_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_cmp_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_ni), .q_o(cmp_sync));

  pcm_edge_det u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sig_i(cyc_sync), .rise_o(cyc_rise));

  assign set_pulse = cyc_rise & en_i;
  assign trip      = ~cmp_sync;

  pcm_on_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clear_i(set_pulse), .run_i(gate_q),
    .blank_i(blank_cnt_i), .max_i(max_on_i),
    .blank_done_o(blank_done), .max_hit_o(max_hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= set_pulse;
      if (!en_i) gate_q <= 1'b0;
      else if (set_pulse) gate_q <= ~trip;  // trip beats set
      else if (gate_q && (max_hit || (trip && blank_done))) gate_q <= 1'b0;
    end
  end

  assign gate_o      = gate_q;
  assign cyc_start_o = start_q;

  assert_gate_rise_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> cyc_start_o);
  assert_start_one_clock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);
  assert_trip_beats_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_pulse && trip) |=> !gate_o);
  assert_disable_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!gate_o && !cyc_start_o));
endmodule

// File: tb/pcm_pwm_latch_bench.sv
`timescale 1ns/1ps
module pcm_pwm_latch_bench;
  localparam int CW = 8;
  logic clk = 0, rst_n = 0, en = 0, cyc = 0, cmp = 1;
  logic [CW-1:0] blank = 0, maxon = 8'd10;
  logic gate, start;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pcm_pwm_latch #(.CNT_W(CW)) u_pcm_pwm_latch (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cyc_clk_i(cyc), .cmp_ni(cmp),
    .blank_cnt_i(blank), .max_on_i(maxon), .gate_o(gate), .cyc_start_o(start));

  // reference model built from the requirements
  logic c1, c2, cd, p1, p2, m_gate, m_start, setp, trp;
  int m_cnt;
  string m_why = "R1";
  bit model_on = 0;

  function automatic bit hit_max(int cnt, int mx);
    return (cnt + 1) >= mx;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= 0; c2 <= 0; cd <= 0; p1 <= 1; p2 <= 1;
      m_gate <= 0; m_start <= 0; m_cnt <= 0; m_why <= "R1";
    end else begin
      setp = c2 & ~cd & en;
      trp  = ~p2;
      c1 <= cyc; c2 <= c1; cd <= c2; p1 <= cmp; p2 <= p1;
      m_start <= setp;
      if (!en) begin m_gate <= 0; m_why <= "R9"; end
      else if (setp && trp) begin m_gate <= 0; m_why <= "R8"; end
      else if (setp) begin m_gate <= 1; m_cnt <= 0; m_why <= m_gate ? "R10" : "R2"; end
      else if (m_gate) begin
        if (hit_max(m_cnt, int'(maxon))) begin m_gate <= 0; m_why <= "R7"; end
        else if (trp && m_cnt >= int'(blank)) begin m_gate <= 0; m_why <= "R5"; end
        else begin m_cnt <= m_cnt + 1; m_why <= trp ? "R6" : "R7"; end
      end else m_why <= "R3";
    end
  end

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check(m_why, gate, m_gate);
    check("R4", start, m_start);
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for gate to rise, optionally drop cmp then, and return the high width
  task automatic width(bit drop_cmp, output int w);
    int t = 0;
    w = 0;
    while (gate !== 1'b1 && t < 50) begin @(negedge clk); t++; end
    if (drop_cmp) cmp = 0;
    while (gate === 1'b1 && w < 300) begin w++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int w, rises;
    bit prev;
    void'($urandom(32'h5eed));
    cycles(3);
    check("R1", gate, 0); check("R1", start, 0);
    cyc = 1; en = 1; cycles(2);
    check("R1", gate, 0); check("R1", start, 0);
    cyc = 0;
    rst_n = 1; cycles(4);
    model_on = 1;

    // R2 latency: gate rises on third edge after cyc_clk_i rises
    maxon = 8'd5; blank = 0;
    cyc = 1; cycles(2); check("R2", gate, 0);
    cycles(1); check("R2", gate, 1); check("R4", start, 1);
    cycles(1); check("R4", start, 0);
    // R7 width of untripped pulse, started above
    w = 2; while (gate === 1'b1 && w < 300) begin w++; @(negedge clk); end
    check_int("R7", w - 1, 5);
    // R3 cycle clock held high: no second pulse
    rises = 0; prev = 0;
    repeat (20) begin @(negedge clk); if (gate && !prev) rises++; prev = gate; end
    check_int("R3", rises, 0);
    cyc = 0; cycles(4);

    // R7 zero acts as one
    maxon = 0; cyc = 1; width(0, w); check_int("R7", w, 1);
    cyc = 0; cycles(4);

    // R6 blanking: trip from first on-cycle, blank=3 -> 4 clocks
    maxon = 8'd50; blank = 8'd3; cyc = 1; width(1, w); check_int("R6", w, 4);
    cyc = 0; cmp = 1; cycles(4);
    // R5 trip without blanking -> 3 clocks (synchronizer delay)
    blank = 0; cyc = 1; width(1, w); check_int("R5", w, 3);
    cyc = 0; cycles(4);

    // R8 trip already active at the set edge
    cyc = 1; cycles(3); check("R8", gate, 0); check("R4", start, 1);
    cycles(5); check("R8", gate, 0);
    cyc = 0; cmp = 1; cycles(4);

    // R10 retrigger mid pulse restarts count
    maxon = 8'd12; cyc = 1; cycles(3); check("R2", gate, 1);
    cycles(2); cyc = 0; cycles(2); cyc = 1;
    cycles(3); check("R10", start, 1);
    w = 0; while (gate === 1'b1 && w < 300) begin w++; @(negedge clk); end
    check_int("R10", w, 12);
    cyc = 0; cycles(4);

    // R9 disabled: edges ignored
    en = 0;
    repeat (3) begin cyc = 1; cycles(4); check("R9", gate, 0); check("R9", start, 0); cyc = 0; cycles(4); end
    en = 1; cycles(4);

    // random traffic checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 12) cyc = ~cyc;
      if ($urandom_range(0, 99) < 15) cmp = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 99) < 2) en = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 199) == 0) begin
        blank = CW'($urandom_range(0, 6));
        maxon = CW'($urandom_range(0, 20));
      end
      @(negedge clk);
    end
    en = 1; cycles(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule